// File: doc/BRIEF.md
# Serial Receive Pattern Compare Start

This block watches a serial receive bit stream, one sampled bit per strobe, and keeps a sliding history of the most recent bits. On every sampled bit it compares the newest N bits of that history against a programmed start pattern. N runs from 1 to 16. A match becomes the receiver's start event. The block then skips a programmed number of bits and opens a data-capture window. In that window it marks each bit that a downstream word assembler should take.

The window closes in one of two ways. By default it closes after a programmed number of captured bits. When the stop option is on, it closes instead on the bit that completes a match against a second pattern, and the data length is then not used. Start matches that arrive while a skip or a window is in progress are ignored. Dropping the receive enable clears the bit history, so bits left over from an earlier frame cannot produce a false match.

The controller has four states:

| State | Meaning | Transitions |
|-------|---------|-------------|
| IDLE | Receiver is off. | Goes to HUNT one clock after enable. |
| HUNT | Compares the start pattern on every sampled bit. | Goes to DELAY on a match with a non-zero skip. Goes to CAPT on a match with a zero skip. |
| DELAY | Discards the skip bits. | Goes to CAPT after the last skip bit. |
| CAPT | The data window. | Goes back to HUNT when the count is reached, or on a stop match. |

Every state goes to IDLE whenever the enable is low.

Top module: `rx_pattern_start`

## Requirements
- R1: While reset is asserted and after it is released, `start_hit`, `stop_hit`, `cap_take`, `cap_bit` and `cap_win` are all low.
- R2: The comparison length is N = `cmp_len_m1`+1. The newest bit sits at history position 0 and is compared with pattern bit 0. Pattern bits at position N and above have no effect.
- R3: In HUNT every sampled bit triggers a comparison. `start_hit` pulses for one clock in the cycle after the edge that sampled the bit completing the match. `start_hit` and `stop_hit` are never high together.
- R4: A match needs at least N bits sampled since the receiver was enabled, counting the current bit.
- R5: After a start match, the next `start_dly` sampled bits are discarded without `cap_take`. The window (`cap_win` high) opens after that. With `start_dly`=0 the window opens at the match edge itself.
- R6: With `stop_en` low, the window takes exactly `data_len_m1`+1 bits. Each taken bit gives a one-clock `cap_take` pulse, with `cap_bit` equal to that bit. After the last bit the block returns to HUNT.
- R7: With `stop_en` high, the window lasts until a bit completes a match of the low N bits of `pat_stop`. That bit is still taken, `stop_hit` pulses, and the block returns to HUNT. `data_len_m1` is not used in this case.
- R8: Start matches during DELAY or CAPT produce no `start_hit` and do not restart the window. This includes a start match on the bit that closes the window.
- R9: With `rx_en` low the block is in IDLE, the history and fill count are cleared, sampled bits are ignored, and `cap_win` is low from the next clock.
- R10: A clock without `bit_valid` changes no state and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; low clears the history |
| bit_valid | input | 1 | Strobe marking a sampled serial bit |
| bit_in | input | 1 | Sampled serial data bit |
| pat_start | input | 16 | Start pattern; bit 0 matches the newest bit |
| pat_stop | input | 16 | Stop pattern; bit 0 matches the newest bit |
| stop_en | input | 1 | Window closes on a stop match instead of on the count |
| cmp_len_m1 | input | 4 | Comparison length minus one |
| start_dly | input | 8 | Bits skipped between the match and the window |
| data_len_m1 | input | 8 | Window length in bits, minus one |
| start_hit | output | 1 | One-clock pulse on an accepted start match |
| stop_hit | output | 1 | One-clock pulse on a stop match that closes the window |
| cap_take | output | 1 | One-clock pulse per bit taken in the window |
| cap_bit | output | 1 | The taken bit, valid with `cap_take` |
| cap_win | output | 1 | High while the data window is open |

## Verification
Two functions can land on the same sampled bit: the bit that closes the window can also complete a start match. The bench provokes this in two ways. The last counted window bit is made to finish the start pattern. In a separate run, the start and stop patterns share their low N bits, so one bit completes both. In both cases the expected result is one `cap_take`, no `start_hit`, a `stop_hit` only when the stop option is on, and a closed window. The following bits then have to form a fresh, complete start match before anything else happens.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HUNT  = 2'd1,
        ST_DELAY = 2'd2,
        ST_CAPT  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/rpc_history.sv
module rpc_history #(
    parameter int HIST_W = 16,
    localparam int LEN_W = $clog2(HIST_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [HIST_W-1:0] pat0,
    input  logic [HIST_W-1:0] pat1,
    output logic              hit0,
    output logic              hit1
);
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_nx;
    logic [LEN_W:0]    fill_q;
    logic [LEN_W:0]    fill_nx;
    logic [HIST_W-1:0] mask;
    logic              filled;

    // Bit position g takes part in the comparison when it lies below N.
    for (genvar g = 0; g < HIST_W; g++) begin : g_mask
        assign mask[g] = (LEN_W'(g) <= len_m1);
    end

    assign hist_nx = {hist_q[HIST_W-2:0], bit_in};
    assign fill_nx = (fill_q == (LEN_W+1)'(HIST_W)) ? fill_q : fill_q + 1'b1;
    assign filled  = (fill_nx > {1'b0, len_m1});

    assign hit0 = rx_en && bit_valid && filled && (((hist_nx ^ pat0) & mask) == '0);
    assign hit1 = rx_en && bit_valid && filled && (((hist_nx ^ pat1) & mask) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (!rx_en) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (bit_valid) begin
            hist_q <= hist_nx;
            fill_q <= fill_nx;
        end
    end
endmodule

// File: rtl/rpc_seq.sv
module rpc_seq
    import rpc_pkg::*;
#(
    parameter int DLY_W  = 8,
    parameter int DLEN_W = 8,
    localparam int CNT_W = (DLY_W > DLEN_W) ? DLY_W : DLEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              hit0,
    input  logic              hit1,
    input  logic              stop_en,
    input  logic [DLY_W-1:0]  start_dly,
    input  logic [DLEN_W-1:0] dlen_m1,
    output rx_state_t         state,
    output logic              start_hit,
    output logic              stop_hit,
    output logic              cap_take,
    output logic              cap_bit
);
    rx_state_t        st_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        st_nx  = state;
        cnt_nx = cnt_q;
        if (!rx_en) begin
            st_nx  = ST_IDLE;
            cnt_nx = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    st_nx  = ST_HUNT;
                    cnt_nx = '0;
                end
                ST_HUNT: begin
                    if (bit_valid && hit0) begin
                        cnt_nx = '0;
                        st_nx  = (start_dly == '0) ? ST_CAPT : ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    if (bit_valid) begin
                        if (cnt_q == CNT_W'(start_dly) - CNT_W'(1)) begin
                            st_nx  = ST_CAPT;
                            cnt_nx = '0;
                        end else begin
                            cnt_nx = cnt_q + 1'b1;
                        end
                    end
                end
                ST_CAPT: begin
                    if (bit_valid) begin
                        if (stop_en) begin
                            if (hit1) begin
                                st_nx  = ST_HUNT;
                                cnt_nx = '0;
                            end
                        end else if (cnt_q == CNT_W'(dlen_m1)) begin
                            st_nx  = ST_HUNT;
                            cnt_nx = '0;
                        end else begin
                            cnt_nx = cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_hit <= 1'b0;
            stop_hit  <= 1'b0;
            cap_take  <= 1'b0;
            cap_bit   <= 1'b0;
        end else begin
            start_hit <= rx_en && bit_valid && (state == ST_HUNT) && hit0;
            stop_hit  <= rx_en && bit_valid && (state == ST_CAPT) && stop_en && hit1;
            cap_take  <= rx_en && bit_valid && (state == ST_CAPT);
            cap_bit   <= rx_en && bit_valid && (state == ST_CAPT) && bit_in;
        end
    end
endmodule

// File: rtl/rx_pattern_start.sv
module rx_pattern_start
    import rpc_pkg::*;
#(
    parameter int HIST_W = 16,
    parameter int DLY_W  = 8,
    parameter int DLEN_W = 8,
    localparam int LEN_W = $clog2(HIST_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic [HIST_W-1:0] pat_start,
    input  logic [HIST_W-1:0] pat_stop,
    input  logic              stop_en,
    input  logic [LEN_W-1:0]  cmp_len_m1,
    input  logic [DLY_W-1:0]  start_dly,
    input  logic [DLEN_W-1:0] data_len_m1,
    output logic              start_hit,
    output logic              stop_hit,
    output logic              cap_take,
    output logic              cap_bit,
    output logic              cap_win
);
    logic      hit0;
    logic      hit1;
    rx_state_t state;

    rpc_history #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .len_m1    (cmp_len_m1),
        .pat0      (pat_start),
        .pat1      (pat_stop),
        .hit0      (hit0),
        .hit1      (hit1)
    );

    rpc_seq #(.DLY_W(DLY_W), .DLEN_W(DLEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .hit0      (hit0),
        .hit1      (hit1),
        .stop_en   (stop_en),
        .start_dly (start_dly),
        .dlen_m1   (data_len_m1),
        .state     (state),
        .start_hit (start_hit),
        .stop_hit  (stop_hit),
        .cap_take  (cap_take),
        .cap_bit   (cap_bit)
    );

    assign cap_win = (state == ST_CAPT);
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             bit_valid,
    input logic             stop_en,
    input logic [DLY_W-1:0] start_dly,
    input logic             start_hit,
    input logic             stop_hit,
    input logic             cap_take,
    input logic             cap_win
);
    assert_start_outside_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |-> !$past(cap_win));

    assert_stop_inside_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |-> ($past(cap_win) && $past(stop_en)));

    assert_stop_closes_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |-> !cap_win);

    assert_take_inside_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_take |-> $past(cap_win));

    assert_window_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |-> (cap_win == (start_dly == '0)));

    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!cap_win && !start_hit && !cap_take && !stop_hit));

    assert_pulse_needs_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_hit || stop_hit || cap_take) |-> $past(bit_valid));

    assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_hit, stop_hit}));
endmodule

bind rx_pattern_start rpc_checker #(.DLY_W(DLY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .bit_valid (bit_valid),
    .stop_en   (stop_en),
    .start_dly (start_dly),
    .start_hit (start_hit),
    .stop_hit  (stop_hit),
    .cap_take  (cap_take),
    .cap_win   (cap_win)
);

// File: tb/rx_pattern_start_tb.sv
module rx_pattern_start_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic [15:0] pat_start = '0;
    logic [15:0] pat_stop = '0;
    logic        stop_en = 1'b0;
    logic [3:0]  cmp_len_m1 = '0;
    logic [7:0]  start_dly = '0;
    logic [7:0]  data_len_m1 = '0;
    logic        start_hit, stop_hit, cap_take, cap_bit, cap_win;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 0;

    typedef struct {
        bit    s;
        bit    p;
        bit    t;
        bit    b;
        bit    w;
        string req;
    } exp_t;
    exp_t sb[$];

    // Reference model: 0 idle, 1 hunt, 2 delay, 3 window
    int          m_st = 0;
    logic [15:0] m_hist = '0;
    int          m_fill = 0;
    int          m_cnt = 0;

    always #(PERIOD/2) clk = ~clk;

    rx_pattern_start u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_valid(bit_valid), .bit_in(bit_in),
        .pat_start(pat_start), .pat_stop(pat_stop), .stop_en(stop_en),
        .cmp_len_m1(cmp_len_m1), .start_dly(start_dly), .data_len_m1(data_len_m1),
        .start_hit(start_hit), .stop_hit(stop_hit), .cap_take(cap_take),
        .cap_bit(cap_bit), .cap_win(cap_win)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {start,stop,take,bit,win} actual %b expected %b at %0t",
                     req, act, exp, $time);
        end
    endtask

    task automatic model_bit(input bit b, input string req, output exp_t e);
        int   n;
        logic [15:0] mask;
        bit   m0, m1;
        e = '{s:0, p:0, t:0, b:0, w:0, req:req};
        m_hist = {m_hist[14:0], b};
        m_fill = (m_fill < 16) ? m_fill + 1 : 16;
        n = int'(cmp_len_m1) + 1;
        mask = (n == 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
        m0 = (m_fill >= n) && (((m_hist ^ pat_start) & mask) == '0);
        m1 = (m_fill >= n) && (((m_hist ^ pat_stop) & mask) == '0);
        case (m_st)
            1: if (m0) begin
                e.s = 1;
                m_cnt = 0;
                m_st = (start_dly == 0) ? 3 : 2;
            end
            2: begin
                m_cnt++;
                if (m_cnt == int'(start_dly)) begin
                    m_st = 3;
                    m_cnt = 0;
                end
            end
            3: begin
                e.t = 1;
                e.b = b;
                if (stop_en) begin
                    if (m1) begin
                        e.p = 1;
                        m_st = 1;
                    end
                end else if (m_cnt == int'(data_len_m1)) begin
                    m_st = 1;
                    m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end
            default: ;
        endcase
        e.w = (m_st == 3);
    endtask

    // Driver: one sampled bit, after an optional gap of idle cycles
    task automatic send_bit(input bit b, input int gap, input string req);
        exp_t e;
        repeat (gap) begin
            @(negedge clk);
            bit_valid = 1'b0;
        end
        @(negedge clk);
        bit_in = b;
        bit_valid = 1'b1;
        model_bit(b, req, e);
        sb.push_back(e);
    endtask

    task automatic send_vec(input logic [63:0] v, input int n, input int gap, input string req);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i], gap, req);
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic rx_on();
        @(negedge clk);
        bit_valid = 1'b0;
        rx_en = 1'b1;
        @(negedge clk);
        m_st = 1;
    endtask

    task automatic rx_off();
        @(negedge clk);
        bit_valid = 1'b0;
        rx_en = 1'b0;
        @(negedge clk);
        check("R9", {start_hit, stop_hit, cap_take, cap_bit, cap_win}, 5'b0);
        m_st = 0;
        m_hist = '0;
        m_fill = 0;
        m_cnt = 0;
    endtask

    task automatic setup(input logic [15:0] p0, input logic [15:0] p1, input bit se,
                         input logic [3:0] lm1, input logic [7:0] dly, input logic [7:0] dl);
        rx_off();
        pat_start = p0;
        pat_stop = p1;
        stop_en = se;
        cmp_len_m1 = lm1;
        start_dly = dly;
        data_len_m1 = dl;
        rx_on();
    endtask

    // Monitor: compares outputs after every edge, popping expectations on sampled bits
    initial begin
        forever begin
            bit v;
            @(posedge clk);
            v = bit_valid;
            @(negedge clk);
            if (mon_on) begin
                if (v) begin
                    if (sb.size() == 0) begin
                        n_chk++;
                        n_bad++;
                        $display("FAIL scoreboard: result with empty queue, actual %b expected none",
                                 {start_hit, stop_hit, cap_take, cap_bit, cap_win});
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(e.req, {start_hit, stop_hit, cap_take, cap_bit, cap_win},
                              {e.s, e.p, e.t, e.b, e.w});
                    end
                end else begin
                    // R10: no pulse without a sampled bit
                    check("R10", {start_hit, stop_hit, cap_take, 2'b00}, 5'b0);
                end
            end
        end
    end

    initial begin
        #(PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {start_hit, stop_hit, cap_take, cap_bit, cap_win}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {start_hit, stop_hit, cap_take, cap_bit, cap_win}, 5'b0);
        mon_on = 1;

        // R2/R3/R5/R6/R8: 4-bit pattern 1011 with garbage upper bits, skip 2, take 4
        setup(16'hFFFB, 16'h0000, 1'b0, 4'd3, 8'd2, 8'd3);
        send_vec(64'b001011_11_1011_0_1011_00_1011, 25, 0, "R2/R3/R5/R6/R8");

        // R10: same stream with idle gaps between bits
        send_vec(64'b0_1011_01_1101, 11, 2, "R10");

        // R2/R5/R6: full 16-bit pattern, zero skip, single-bit window
        setup(16'hC3A5, 16'h0000, 1'b0, 4'd15, 8'd0, 8'd0);
        send_vec(64'h5_C3A5_1_C3A5_0, 40, 0, "R2/R5/R6");

        // R7: stop pattern closes the window, data length ignored
        setup(16'hAB7E, 16'h5581, 1'b1, 4'd7, 8'd1, 8'd0);
        send_vec(64'b0111_1110_1_0011_0101_1000_0001_0111_1110, 37, 0, "R7");

        // R7/R8: one bit completes both patterns; stop wins, start ignored
        setup(16'h0009, 16'h0009, 1'b1, 4'd3, 8'd0, 8'd5);
        send_vec(64'b1001_0110_1001_1001_0, 17, 1, "R7/R8");

        // R8: last counted window bit completes the start pattern
        setup(16'h0006, 16'h0000, 1'b0, 4'd2, 8'd0, 8'd2);
        send_vec(64'b110_110_0_110, 10, 0, "R8");

        // R4: all-zero pattern needs N bits after enable
        setup(16'h0000, 16'h0000, 1'b0, 4'd4, 8'd3, 8'd1);
        send_vec(64'b0000_0, 5, 0, "R4");

        // R9: disable inside the window, then re-enable with a cleared history
        setup(16'h0001, 16'h0000, 1'b0, 4'd0, 8'd0, 8'd7);
        send_vec(64'b1_010, 4, 0, "R9");
        rx_off();
        pat_start = 16'h0000;
        cmp_len_m1 = 4'd2;
        rx_on();
        send_vec(64'b000_11, 5, 0, "R4/R9");

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL scoreboard: actual %0d leftover expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule